// File: doc/BRIEF.md
# Vector ALU issue pipeline with result forwarding

This block models the timing of a vector ALU issue path. Each instruction carries a destination register index and up to `NSRC` source register indices, and each source can be marked unused, which means it is a constant. An accepted instruction waits in a small holding area until its operands are available. It then walks through `ALU_DEPTH` execute stages and a single writeback stage. While the instruction is in writeback, the block raises a one-cycle completion pulse that carries the destination index. Data values, arithmetic and decode are not modelled. Only admission timing and completion events are produced.

A per-register busy bit is set when an instruction enters the first execute stage and is cleared when it leaves writeback. The admission check works on the state of the same clock edge. The destination of the instruction leaving the last execute stage counts as available, and so does the destination of the instruction in writeback. A waiting dependent can therefore enter stage 0 on the very edge its producer moves into writeback. Admission picks at most one instruction per cycle: the oldest waiting entry that has spent a full cycle waiting, has its operands ready, and has no ordering conflict with an older waiting entry.

Top module: `valu_fwd_pipe`

## Requirements
- R1: After synchronous reset, issue_ready is 1 and done_valid is 0. An instruction accepted before the reset never produces a completion pulse.
- R2: An instruction whose sources are all unused (issue_src_used bits 0) gives exactly one done_valid pulse, with done_dst equal to its destination, 6 cycles after the edge that accepted it.
- R3: A waiting dependent enters stage 0 on the edge its producer leaves the last execute stage. In a chain issued on consecutive cycles, the completion pulses are 4 cycles apart. A dependent accepted 4 cycles after its producer also completes 4 cycles after it.
- R4: A source whose producer is in writeback counts as ready. A dependent accepted 5 cycles after its producer completes 5 cycles after it. One accepted 6 cycles after completes 6 cycles after it.
- R5: At most one instruction is admitted per cycle, oldest first. Two dependents of one producer, accepted on the two cycles after it, complete 4 and 5 cycles after the producer.
- R6: A younger independent instruction is admitted past an older blocked one. It completes 6 cycles after acceptance, before the blocked one completes.
- R7: A waiting entry does not overtake an older waiting entry whose destination it reads or writes, or whose source it writes. For a read-after-write, the younger entry completes 4 cycles after the older one. For a write-after-write to the same register, the second completion comes 5 cycles after the first.
- R8: issue_ready is 0 while DF_DEPTH (4) instructions are waiting. An issue_valid presented while issue_ready is 0 is ignored and never produces a completion pulse.
- R9: Every accepted instruction produces exactly one completion pulse for its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Offer an instruction this cycle |
| issue_dst | input | REG_W | Destination register index |
| issue_src_used | input | NSRC | Bit s set: source s is a register, clear: constant |
| issue_src | input | NSRC*REG_W | Source s index at bits [s*REG_W +: REG_W] |
| issue_ready | output | 1 | Holding area can take an instruction |
| done_valid | output | 1 | Completion pulse, one cycle per instruction |
| done_dst | output | REG_W | Destination of the completing instruction |

## Verification
The hardest situations to reach are the exact arrival windows around a producer's last two stages: a dependent that arrives just in time for the forwarded result, one that catches the producer only in writeback, and one that arrives after the busy bit has cleared. Directed sequences reach them by varying the idle gap between producer and consumer from three to five cycles and measuring the distance between completion pulses. A filled holding area and the write-after-write stall are also set up directly with back-to-back dependents on one producer. A seeded random stream then mixes dependencies and stalls, and the bench checks that each destination receives one completion per accepted instruction.

// File: rtl/valu_pkg.sv
package valu_pkg;
  parameter int REG_W = 4;
  parameter int NSRC  = 2;
  localparam int NREG = 1 << REG_W;

  typedef logic [REG_W-1:0] reg_idx_t;

  typedef struct packed {
    logic [NSRC-1:0]           src_used;
    logic [NSRC-1:0][REG_W-1:0] src;
    reg_idx_t                  dst;
  } uop_t;

  // True when the younger entry must not pass the older one
  function automatic logic uop_clash(input uop_t older, input uop_t younger);
    logic c;
    c = (older.dst == younger.dst);
    for (int s = 0; s < NSRC; s++) begin
      if (younger.src_used[s] && (younger.src[s] == older.dst)) c = 1'b1;
      if (older.src_used[s] && (older.src[s] == younger.dst)) c = 1'b1;
    end
    return c;
  endfunction
endpackage

// File: rtl/valu_depfetch.sv
module valu_depfetch
  import valu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  uop_t            in_uop,
  input  logic [NREG-1:0] busy,
  input  logic            fwd_vld,
  input  reg_idx_t        fwd_dst,
  input  logic            wb_vld,
  input  reg_idx_t        wb_dst,
  output logic            full,
  output logic            adm_vld,
  output reg_idx_t        adm_dst
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] aged_q;
  logic [DEPTH-1:0] elig;
  uop_t             uop_q [DEPTH];

  logic [NREG-1:0]  pend;
  logic [IDX_W-1:0] sel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] base;
  logic             acc;
  logic [DEPTH-1:0] sh_vld;
  uop_t             sh_uop [DEPTH];

  // A register in writeback is released on this edge
  always_comb begin
    pend = busy;
    if (wb_vld) pend[wb_dst] = 1'b0;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic ops_ok;
    logic order_ok;
    always_comb begin
      ops_ok = !pend[uop_q[i].dst];
      for (int s = 0; s < NSRC; s++) begin
        if (uop_q[i].src_used[s] && pend[uop_q[i].src[s]] &&
            !(fwd_vld && (fwd_dst == uop_q[i].src[s])))
          ops_ok = 1'b0;
      end
      order_ok = 1'b1;
      for (int j = 0; j < i; j++) begin
        if (vld_q[j] && uop_clash(uop_q[j], uop_q[i])) order_ok = 1'b0;
      end
    end
    assign elig[i] = vld_q[i] && aged_q[i] && ops_ok && order_ok;
  end

  // Oldest eligible entry wins
  always_comb begin
    adm_vld = 1'b0;
    sel     = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (elig[k]) begin
        adm_vld = 1'b1;
        sel     = IDX_W'(k);
      end
    end
  end

  assign adm_dst = uop_q[sel].dst;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < DEPTH; k++) cnt = cnt + CNT_W'(vld_q[k]);
  end

  assign full = vld_q[DEPTH-1];
  assign acc  = in_vld && !full;

  // Close the gap left by the admitted entry
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      sh_vld[k] = vld_q[k];
      sh_uop[k] = uop_q[k];
      if (adm_vld && (k >= int'(sel))) begin
        if (k < DEPTH - 1) begin
          sh_vld[k] = vld_q[(k < DEPTH - 1) ? k + 1 : k];
          sh_uop[k] = uop_q[(k < DEPTH - 1) ? k + 1 : k];
        end else begin
          sh_vld[k] = 1'b0;
        end
      end
    end
    base = cnt - CNT_W'(adm_vld);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      aged_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        vld_q[k]  <= sh_vld[k];
        aged_q[k] <= sh_vld[k];
        if (acc && (base == CNT_W'(k))) begin
          vld_q[k]  <= 1'b1;
          aged_q[k] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      uop_q[k] <= sh_uop[k];
      if (acc && (base == CNT_W'(k))) uop_q[k] <= in_uop;
    end
  end
endmodule

// File: rtl/valu_scoreboard.sv
module valu_scoreboard
  import valu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            set_vld,
  input  reg_idx_t        set_dst,
  input  logic            clr_vld,
  input  reg_idx_t        clr_dst,
  output logic [NREG-1:0] busy
);
  logic [NREG-1:0] set_m;
  logic [NREG-1:0] clr_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (set_vld) set_m[set_dst] = 1'b1;
    if (clr_vld) clr_m[clr_dst] = 1'b1;
  end

  // Setting wins when one register is released and claimed together
  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~clr_m) | set_m;
  end
endmodule

// File: rtl/valu_alu_pipe.sv
module valu_alu_pipe
  import valu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     adm_vld,
  input  reg_idx_t adm_dst,
  output logic     fwd_vld,
  output reg_idx_t fwd_dst,
  output logic     wb_vld,
  output reg_idx_t wb_dst
);
  logic [DEPTH-1:0] st_vld;
  reg_idx_t         st_dst [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_vld <= '0;
      wb_vld <= 1'b0;
    end else begin
      st_vld[0] <= adm_vld;
      for (int g = 1; g < DEPTH; g++) st_vld[g] <= st_vld[g-1];
      wb_vld <= st_vld[DEPTH-1];
    end
  end

  always_ff @(posedge clk) begin
    st_dst[0] <= adm_dst;
    for (int g = 1; g < DEPTH; g++) st_dst[g] <= st_dst[g-1];
    wb_dst <= st_dst[DEPTH-1];
  end

  assign fwd_vld = st_vld[DEPTH-1];
  assign fwd_dst = st_dst[DEPTH-1];
endmodule

// File: rtl/valu_fwd_pipe.sv
module valu_fwd_pipe
  import valu_pkg::*;
#(
  parameter int DF_DEPTH  = 4,
  parameter int ALU_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue_valid,
  input  logic [REG_W-1:0]      issue_dst,
  input  logic [NSRC-1:0]       issue_src_used,
  input  logic [NSRC*REG_W-1:0] issue_src,
  output logic                  issue_ready,
  output logic                  done_valid,
  output logic [REG_W-1:0]      done_dst
);
  uop_t            in_uop;
  logic [NREG-1:0] sb_busy;
  logic            adm_vld;
  reg_idx_t        adm_dst;
  logic            fwd_vld;
  reg_idx_t        fwd_dst;
  logic            wb_vld;
  reg_idx_t        wb_dst;
  logic            df_full;

  always_comb begin
    in_uop.dst      = issue_dst;
    in_uop.src_used = issue_src_used;
    for (int s = 0; s < NSRC; s++) in_uop.src[s] = issue_src[s*REG_W +: REG_W];
  end

  valu_depfetch #(.DEPTH(DF_DEPTH)) u_df (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (issue_valid),
    .in_uop  (in_uop),
    .busy    (sb_busy),
    .fwd_vld (fwd_vld),
    .fwd_dst (fwd_dst),
    .wb_vld  (wb_vld),
    .wb_dst  (wb_dst),
    .full    (df_full),
    .adm_vld (adm_vld),
    .adm_dst (adm_dst)
  );

  valu_scoreboard u_sb (
    .clk     (clk),
    .rst     (rst),
    .set_vld (adm_vld),
    .set_dst (adm_dst),
    .clr_vld (wb_vld),
    .clr_dst (wb_dst),
    .busy    (sb_busy)
  );

  valu_alu_pipe #(.DEPTH(ALU_DEPTH)) u_alu (
    .clk     (clk),
    .rst     (rst),
    .adm_vld (adm_vld),
    .adm_dst (adm_dst),
    .fwd_vld (fwd_vld),
    .fwd_dst (fwd_dst),
    .wb_vld  (wb_vld),
    .wb_dst  (wb_dst)
  );

  assign issue_ready = !df_full;
  assign done_valid  = wb_vld;
  assign done_dst    = wb_dst;
endmodule

// File: rtl/valu_fwd_pipe_chk.sv
module valu_fwd_pipe_chk
  import valu_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            issue_ready,
  input logic            done_valid,
  input reg_idx_t        done_dst,
  input logic [NREG-1:0] sb_busy,
  input logic            adm_vld,
  input reg_idx_t        adm_dst,
  input logic            fwd_vld,
  input reg_idx_t        fwd_dst
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done_valid && issue_ready)); // R1

  AST_DONE_CLAIMED: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> sb_busy[done_dst]); // R9

  AST_FWD_CLAIMED: assert property (@(posedge clk) disable iff (rst)
    fwd_vld |-> sb_busy[fwd_dst]); // R3

  AST_ADMIT_DEST_FREE: assert property (@(posedge clk) disable iff (rst)
    adm_vld |-> (!sb_busy[adm_dst] || (done_valid && (done_dst == adm_dst)))); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(issue_ready) && !$past(adm_vld)) |-> !issue_ready); // R8
endmodule

bind valu_fwd_pipe valu_fwd_pipe_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_ready (issue_ready),
  .done_valid  (done_valid),
  .done_dst    (done_dst),
  .sb_busy     (sb_busy),
  .adm_vld     (adm_vld),
  .adm_dst     (adm_dst),
  .fwd_vld     (fwd_vld),
  .fwd_dst     (fwd_dst)
);

// File: tb/valu_fwd_pipe_test.sv
module valu_fwd_pipe_test;
  import valu_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  issue_valid = 1'b0;
  logic [REG_W-1:0]      issue_dst = '0;
  logic [NSRC-1:0]       issue_src_used = '0;
  logic [NSRC*REG_W-1:0] issue_src = '0;
  logic                  issue_ready;
  logic                  done_valid;
  logic [REG_W-1:0]      done_dst;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int first_done [NREG];
  int last_done  [NREG];
  int ndone      [NREG];
  int nacc       [NREG];

  valu_fwd_pipe uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_dst(issue_dst),
    .issue_src_used(issue_src_used), .issue_src(issue_src), .issue_ready(issue_ready),
    .done_valid(done_valid), .done_dst(done_dst)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && done_valid) begin
      if (ndone[done_dst] == 0) first_done[done_dst] = cyc;
      last_done[done_dst] = cyc;
      ndone[done_dst]++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clear_logs();
    for (int r = 0; r < NREG; r++) begin
      first_done[r] = 0; last_done[r] = 0; ndone[r] = 0; nacc[r] = 0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_logs();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; returns at the next negedge with the accepting edge index
  task automatic issue(input int d, input bit u0, input int s0, input bit u1, input int s1,
                       output int acc);
    issue_valid    = 1'b1;
    issue_dst      = REG_W'(d);
    issue_src_used = {u1, u0};
    issue_src      = {REG_W'(s1), REG_W'(s0)};
    @(negedge clk);
    acc = cyc;
    issue_valid = 1'b0;
  endtask

  function automatic int gap_expect(input int k);
    // dependent accepted k+1 cycles after its producer
    return (k + 1 <= 4) ? 4 : k + 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    int a, b, c, d0;
    int unsigned seed;
    seed = $urandom(32'd4711);
    clear_logs();
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 ready after reset", int'(issue_ready), 1);
    chk("R1 done low after reset", int'(done_valid), 0);

    // R2 constant sources
    issue(1, 0, 0, 0, 0, a);
    idle(12);
    chk("R2 latency", last_done[1] - a, 6);
    chk("R2 single pulse", ndone[1], 1);

    // R3 back-to-back chain
    do_reset();
    issue(2, 0, 0, 0, 0, a);
    issue(3, 1, 2, 0, 0, b);
    issue(4, 1, 3, 1, 3, c);
    idle(20);
    chk("R3 first dependent spacing", last_done[3] - last_done[2], 4);
    chk("R3 second dependent spacing", last_done[4] - last_done[3], 4);

    // R3/R4 arrival windows
    for (int k = 3; k <= 5; k++) begin
      do_reset();
      issue(5, 0, 0, 0, 0, a);
      idle(k);
      issue(6, 0, 0, 1, 5, b);
      idle(20);
      chk((k == 3) ? "R3 late arrival forwarded" : "R4 writeback window",
          last_done[6] - last_done[5], gap_expect(k));
    end

    // R5 two dependents of one producer
    do_reset();
    issue(6, 0, 0, 0, 0, a);
    issue(7, 1, 6, 0, 0, b);
    issue(8, 1, 6, 0, 0, c);
    idle(20);
    chk("R5 first admitted", last_done[7] - last_done[6], 4);
    chk("R5 second admitted next cycle", last_done[8] - last_done[6], 5);

    // R6 independent passes blocked entry
    do_reset();
    issue(9, 0, 0, 0, 0, a);
    issue(10, 1, 9, 0, 0, b);
    issue(11, 0, 0, 0, 0, c);
    idle(20);
    chk("R6 independent latency", last_done[11] - c, 6);
    chk("R6 completes before blocked", int'(last_done[11] < last_done[10]), 1);

    // R7 read-after-write on a waiting entry
    do_reset();
    issue(12, 0, 0, 0, 0, a);
    issue(13, 1, 12, 0, 0, b);
    issue(14, 0, 0, 1, 13, c);
    idle(24);
    chk("R7 raw order", last_done[14] - last_done[13], 4);

    // R7 write-after-write
    do_reset();
    issue(15, 0, 0, 0, 0, a);
    issue(0, 1, 15, 0, 0, b);
    issue(0, 0, 0, 0, 0, c);
    idle(24);
    chk("R7 waw count", ndone[0], 2);
    chk("R7 waw spacing", last_done[0] - first_done[0], 5);

    // R8 full holding area
    do_reset();
    issue(1, 0, 0, 0, 0, a);
    for (int k = 2; k <= 5; k++) issue(k, 1, 1, 0, 0, b);
    chk("R8 ready low when full", int'(issue_ready), 0);
    issue_valid = 1'b1;
    issue_dst   = REG_W'(9);
    issue_src_used = '0;
    @(negedge clk);
    issue_valid = 1'b0;
    idle(30);
    chk("R8 ignored issue", ndone[9], 0);
    for (int k = 2; k <= 5; k++) chk("R8 waiting entries complete", ndone[k], 1);
    chk("R8 ready restored", int'(issue_ready), 1);

    // R1 reset drops work in flight
    do_reset();
    issue(3, 0, 0, 0, 0, a);
    idle(2);
    do_reset();
    idle(15);
    chk("R1 flushed instruction", ndone[3], 0);
    chk("R1 ready after flush", int'(issue_ready), 1);

    // R9 random stream
    do_reset();
    for (int it = 0; it < 800; it++) begin
      if (($urandom % 4) != 0) begin
        issue_valid    = 1'b1;
        d0             = int'($urandom % NREG);
        issue_dst      = REG_W'(d0);
        issue_src_used = NSRC'($urandom);
        issue_src      = (NSRC*REG_W)'($urandom);
        if (issue_ready) nacc[d0]++;
      end else begin
        issue_valid = 1'b0;
      end
      @(negedge clk);
    end
    issue_valid = 1'b0;
    idle(80);
    for (int r = 0; r < NREG; r++) chk("R9 completions per destination", ndone[r], nacc[r]);

    summary();
  end
endmodule